// File: doc/BRIEF.md
# Parallel Asynchronous Configuration Loader

This controller sits on the host side and feeds a configuration image into a target device over a byte-wide parallel bus. It takes the image from a valid/ready byte stream and places each byte on the data bus. It then pulses an active-low write strobe and waits for the target to finish with that byte. The target shows that it is working by holding its ready/busy line low. The length of that busy period is set by the target's own free-running oscillator, so it changes with temperature, supply and silicon. At 200 MHz the window runs from 80 to 320 controller cycles.

Configuration images end with padding bytes that are all ones, so the target's configuration-done signal can rise before the stream is finished. A build parameter picks one of two modes. In the first mode, loading ends as soon as done is seen: the bus is released and the rest of the stream is accepted and thrown away. In the second mode every byte is written. The controller ends in one of three terminal states (done, busy timeout, or stream finished without done) and reports it on a status code. It stays in that state until reset.

Top module: `cfg_loader`

## Requirements
- R1: A byte taken from the stream on a cycle with `in_valid` and `in_ready` both high appears on `cfg_data` on the next cycle, with `cfg_data_oe` high. It stays there unchanged until the next byte is taken. While `cfg_data_oe` is low, `cfg_data` reads zero.
- R2: `cfg_wr_n` goes low `SETUP_CYC` cycles after the cycle in which the byte was taken, and stays low for exactly `STROBE_CYC` cycles.
- R3: After the strobe rises, the controller waits `HOLD_CYC` cycles. It then needs the ready/busy line to go low and then return high before it takes the next byte. The strobe never falls while the target holds ready/busy low. This holds for any busy length from 80 to 320 cycles.
- R4: The value on `cfg_data` does not change while `cfg_wr_n` is low, nor in the cycle after it rises.
- R5: With `STOP_AT_DONE`=1, configuration-done is checked when each busy cycle ends. If it is high then, the controller releases the bus. It then accepts and discards the remaining stream bytes, up to and including the one marked `in_last`, and reports done.
- R6: In every terminal state, `cfg_data_oe` is 0, `cfg_data` is 0 and `cfg_wr_n` is 1.
- R7: `ld_status` reads 0 while loading, 1 for done, 2 for busy timeout and 3 for a stream that ended without done. Once it is non-zero, it holds its value until reset.
- R8: `in_ready` is high only while the controller waits for the next byte or discards bytes after done. It is never high during the setup, strobe, hold or busy phases.
- R9: With `STOP_AT_DONE`=0, every stream byte is written to the target. Done is judged only after the busy cycle of the byte marked `in_last`.
- R10: If the busy watch, counted from its first cycle, lasts `TIMEOUT_CYC` cycles without the low-then-high sequence completing, the status becomes 2.
- R11: If the busy cycle of the byte marked `in_last` completes while done is low, the status becomes 3.
- R12: `tgt_rdy_busy` and `tgt_conf_done` pass through two flops, so a change on either line affects the controller on the second rising clock edge after it appears.
- R13: While reset is held, `cfg_data_oe` is 0, `cfg_wr_n` is 1, `in_ready` is 1 and `ld_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte available |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Controller takes a byte this cycle |
| cfg_data | output | 8 | Byte driven to the target |
| cfg_data_oe | output | 1 | Output enable for the data bus |
| cfg_wr_n | output | 1 | Active-low write strobe |
| tgt_rdy_busy | input | 1 | Target ready (high) / busy (low), asynchronous |
| tgt_conf_done | input | 1 | Target configuration-done, asynchronous |
| ld_status | output | 2 | 0 loading, 1 done, 2 timeout, 3 no done |

## Verification
Both modes run the same set of streams against a target model. In that model, busy lengths change from byte to byte and include the 80- and 320-cycle extremes, which shows that the controller waits on the line and not on a fixed delay. Some streams have done rising part-way through the padding. These show the difference between discarding the rest (stop mode) and writing every byte (send-all mode). A stream whose last byte is also the done byte covers the boundary case, and a stream that never raises done must end in status 3. Other cases use a target that stays busy forever, which must lead to the timeout and the bus release, and idle gaps on the input stream, which check that the controller waits on `in_valid` instead of its own timing.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;

    localparam int unsigned CFG_BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_BUSY_LO,
        ST_BUSY_HI,
        ST_DRAIN,
        ST_DONE,
        ST_ERR_TMO,
        ST_ERR_NODONE
    } ld_state_e;

    typedef enum logic [1:0] {
        LD_RUN     = 2'd0,
        LD_DONE    = 2'd1,
        LD_TIMEOUT = 2'd2,
        LD_NODONE  = 2'd3
    } ld_status_e;

    typedef struct packed {
        ld_state_e              state;
        logic [CFG_BYTE_W-1:0]  data;
        logic                   last;
    } ld_regs_t;

    // Phases in which the controller is watching the target's busy handshake.
    function automatic logic is_busy_watch(ld_state_e s);
        return (s == ST_BUSY_LO) || (s == ST_BUSY_HI);
    endfunction

    // Phases in which the controller owns the data bus.
    function automatic logic drives_bus(ld_state_e s);
        return (s == ST_FETCH) || (s == ST_SETUP) || (s == ST_STROBE) ||
               (s == ST_HOLD)  || is_busy_watch(s);
    endfunction

endpackage

// File: rtl/cfgld_sync.sv
`timescale 1ns/1ps
// Multi-bit bank of independent flop chains for asynchronous level inputs.
module cfgld_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgld_cycle_cnt.sv
`timescale 1ns/1ps
// Saturating up-counter: holds zero in the cycle after a clear.
module cfgld_cycle_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count_o
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr)                 count_d = '0;
        else if (count_q != '1)  count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader
    import cfgld_pkg::*;
#(
    parameter int unsigned SETUP_CYC    = 2,
    parameter int unsigned STROBE_CYC   = 3,
    parameter int unsigned HOLD_CYC     = 2,
    parameter int unsigned TIMEOUT_CYC  = 400,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter bit          STOP_AT_DONE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [CFG_BYTE_W-1:0] in_data,
    input  logic                  in_last,
    output logic                  in_ready,
    output logic [CFG_BYTE_W-1:0] cfg_data,
    output logic                  cfg_data_oe,
    output logic                  cfg_wr_n,
    input  logic                  tgt_rdy_busy,
    input  logic                  tgt_conf_done,
    output logic [1:0]            ld_status
);
    localparam int unsigned PH_MAX0 = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int unsigned PH_MAX  = (PH_MAX0 > HOLD_CYC) ? PH_MAX0 : HOLD_CYC;
    localparam int unsigned PH_W    = $clog2(PH_MAX + 1);
    localparam int unsigned TMO_W   = $clog2(TIMEOUT_CYC + 1);

    localparam logic [PH_W-1:0]  SETUP_LAST  = PH_W'(SETUP_CYC - 1);
    localparam logic [PH_W-1:0]  STROBE_LAST = PH_W'(STROBE_CYC - 1);
    localparam logic [PH_W-1:0]  HOLD_LAST   = PH_W'(HOLD_CYC - 1);
    localparam logic [TMO_W-1:0] TMO_LAST    = TMO_W'(TIMEOUT_CYC - 1);

    ld_regs_t         cur, nxt;
    logic             rdy_s, done_s;
    logic             ph_clr, tmo_clr;
    logic [PH_W-1:0]  ph_cnt;
    logic [TMO_W-1:0] tmo_cnt;

    // Target lines are asynchronous to clk.
    cfgld_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tgt_conf_done, tgt_rdy_busy}),
        .sync_o  ({done_s, rdy_s})
    );

    // Cycles spent in the current setup/strobe/hold phase.
    cfgld_cycle_cnt #(.W(PH_W)) u_phase_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ph_clr),
        .count_o (ph_cnt)
    );

    // Cycles spent in the busy watch as a whole (low and high halves).
    cfgld_cycle_cnt #(.W(TMO_W)) u_tmo_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmo_clr),
        .count_o (tmo_cnt)
    );

    always_comb begin
        nxt      = cur;
        in_ready = 1'b0;
        unique case (cur.state)
            ST_IDLE, ST_FETCH: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    nxt.data  = in_data;
                    nxt.last  = in_last;
                    nxt.state = ST_SETUP;
                end
            end
            ST_SETUP:  if (ph_cnt == SETUP_LAST)  nxt.state = ST_STROBE;
            ST_STROBE: if (ph_cnt == STROBE_LAST) nxt.state = ST_HOLD;
            ST_HOLD:   if (ph_cnt == HOLD_LAST)   nxt.state = ST_BUSY_LO;
            ST_BUSY_LO: begin
                if (!rdy_s)                   nxt.state = ST_BUSY_HI;
                else if (tmo_cnt == TMO_LAST) nxt.state = ST_ERR_TMO;
            end
            ST_BUSY_HI: begin
                if (rdy_s) begin
                    // Done is only meaningful once the busy cycle has closed.
                    if (cur.last)                    nxt.state = done_s ? ST_DONE : ST_ERR_NODONE;
                    else if (done_s && STOP_AT_DONE) nxt.state = ST_DRAIN;
                    else                             nxt.state = ST_FETCH;
                end else if (tmo_cnt == TMO_LAST) begin
                    nxt.state = ST_ERR_TMO;
                end
            end
            ST_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && in_last) nxt.state = ST_DONE;
            end
            default: ;
        endcase
        ph_clr  = (nxt.state != cur.state);
        tmo_clr = !(is_busy_watch(cur.state) && is_busy_watch(nxt.state));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= '{state: ST_IDLE, data: '0, last: 1'b0};
        else        cur <= nxt;
    end

    always_comb begin
        cfg_data_oe = drives_bus(cur.state);
        cfg_data    = cfg_data_oe ? cur.data : '0;
        cfg_wr_n    = (cur.state != ST_STROBE);
        unique case (cur.state)
            ST_DONE:       ld_status = LD_DONE;
            ST_ERR_TMO:    ld_status = LD_TIMEOUT;
            ST_ERR_NODONE: ld_status = LD_NODONE;
            default:       ld_status = LD_RUN;
        endcase
    end
endmodule

// File: rtl/cfgld_checker.sv
`timescale 1ns/1ps
module cfgld_checker #(
    parameter int unsigned STROBE_CYC = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_data,
    input logic       cfg_data_oe,
    input logic       cfg_wr_n,
    input logic       in_ready,
    input logic [1:0] ld_status
);
    // Data frozen while the strobe is low and in the cycle after it rises.
    p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_n || !$past(cfg_wr_n)) |-> $stable(cfg_data));

    // Strobe low time spans more than one cycle when configured so.
    p_strobe_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((STROBE_CYC > 1) && $fell(cfg_wr_n)) |=> !cfg_wr_n);

    // Terminal states leave the bus released.
    p_bus_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_status != 2'd0) |-> (!cfg_data_oe && cfg_wr_n && (cfg_data == 8'h00)));

    // Terminal status holds until reset.
    p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_status != 2'd0) |=> $stable(ld_status));

    // No new byte taken while a write is in flight.
    p_no_accept_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_n |-> !in_ready);
endmodule

bind cfg_loader cfgld_checker #(.STROBE_CYC(STROBE_CYC)) u_cfgld_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_data    (cfg_data),
    .cfg_data_oe (cfg_data_oe),
    .cfg_wr_n    (cfg_wr_n),
    .in_ready    (in_ready),
    .ld_status   (ld_status)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
// One controller plus target model plus reference model, for one mode.
module cfg_loader_lane #(
    parameter bit STOP = 1'b1
) (
    input logic clk
);
    localparam int SETUP = 2, STROBE = 3, HOLD = 2, TMO = 400;
    localparam int P_IDLE = 0, P_FETCH = 1, P_SETUP = 2, P_STROBE = 3, P_HOLD = 4,
                   P_WLO = 5, P_WHI = 6, P_DRAIN = 7, P_END = 8;

    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [7:0] in_data = 8'h00, cfg_data;
    logic       cfg_data_oe, cfg_wr_n;
    logic       tgt_rdy = 1'b1, tgt_done = 1'b0;
    logic [1:0] ld_status;

    int checks = 0, errors = 0;
    logic fin = 1'b0;
    int sc_done_at = 1000, sc_stuck = -1;

    cfg_loader #(
        .SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .HOLD_CYC(HOLD),
        .TIMEOUT_CYC(TMO), .SYNC_STAGES(2), .STOP_AT_DONE(STOP)
    ) u_cfg_loader (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .cfg_data(cfg_data),
        .cfg_data_oe(cfg_data_oe), .cfg_wr_n(cfg_wr_n),
        .tgt_rdy_busy(tgt_rdy), .tgt_conf_done(tgt_done), .ld_status(ld_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s stop=%0d t=%0t: got %0d expected %0d", req, STOP, $time, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(int i, int d);
        return (i >= d) ? 8'hFF : 8'((i * 37 + 5) & 255);
    endfunction

    function automatic int busy_len(int i);
        if (i == 0) return 80;    // 0.4 us
        if (i == 1) return 320;   // 1.6 us
        return 80 + (i * 97) % 241;
    endfunction

    // ---------------- reference model, stepped on every rising edge ----------------
    int m_ph = P_IDLE, m_cnt = 0, m_tmo = 0, m_stat = 0;
    logic [7:0] m_byte = 8'h00;
    logic m_last = 1'b0, m_r1 = 1'b0, m_r2 = 1'b0, m_d1 = 1'b0, m_d2 = 1'b0, m_live = 1'b0;
    logic e_wr_n = 1'b1, e_oe = 1'b0, e_rdy = 1'b1;
    logic [7:0] e_data = 8'h00;
    int e_stat = 0;

    always @(posedge clk) begin : mdl
        logic rs, ds;
        rs = m_r2; ds = m_d2;
        // R12: two-edge delay on the target lines
        m_r2 = m_r1; m_d2 = m_d1; m_r1 = tgt_rdy; m_d1 = tgt_done;
        if (!rst_n) begin
            m_r1 = 0; m_r2 = 0; m_d1 = 0; m_d2 = 0;
            m_ph = P_IDLE; m_cnt = 0; m_tmo = 0; m_byte = 0; m_last = 0; m_live = 0;
        end else begin
            m_live = 1;
            case (m_ph)
                P_IDLE, P_FETCH:
                    if (in_valid) begin m_byte = in_data; m_last = in_last; m_ph = P_SETUP; m_cnt = 0; end
                P_SETUP:  if (m_cnt == SETUP - 1)  begin m_ph = P_STROBE; m_cnt = 0; end else m_cnt++;
                P_STROBE: if (m_cnt == STROBE - 1) begin m_ph = P_HOLD;   m_cnt = 0; end else m_cnt++;
                P_HOLD:   if (m_cnt == HOLD - 1)   begin m_ph = P_WLO;    m_tmo = 0; end else m_cnt++;
                P_WLO:
                    if (!rs) begin m_ph = P_WHI; m_tmo++; end
                    else if (m_tmo == TMO - 1) begin m_ph = P_END; m_stat = 2; end
                    else m_tmo++;
                P_WHI:
                    if (rs) begin
                        if (m_last) begin m_ph = P_END; m_stat = ds ? 1 : 3; end
                        else if (ds && STOP) m_ph = P_DRAIN;
                        else m_ph = P_FETCH;
                    end else if (m_tmo == TMO - 1) begin m_ph = P_END; m_stat = 2; end
                    else m_tmo++;
                P_DRAIN:
                    if (in_valid && in_last) begin m_ph = P_END; m_stat = 1; end
                default: ;
            endcase
        end
        e_wr_n = (m_ph != P_STROBE);
        e_oe   = (m_ph >= P_FETCH) && (m_ph <= P_WHI);
        e_data = e_oe ? m_byte : 8'h00;
        e_rdy  = (m_ph == P_IDLE) || (m_ph == P_FETCH) || (m_ph == P_DRAIN);
        e_stat = (m_ph == P_END) ? m_stat : 0;
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (m_live) begin
            check(cfg_wr_n == e_wr_n, "R2 strobe", int'(cfg_wr_n), int'(e_wr_n));
            check(cfg_data == e_data, "R1 data", int'(cfg_data), int'(e_data));
            check(cfg_data_oe == e_oe, "R1/R6 enable", int'(cfg_data_oe), int'(e_oe));
            check(in_ready == e_rdy, "R8 ready", int'(in_ready), int'(e_rdy));
            check(int'(ld_status) == e_stat, "R7 status", int'(ld_status), e_stat);
        end
    end

    // ---------------- target model ----------------
    logic [7:0] rx_q[$];
    logic prev_wr = 1'b1;
    logic [7:0] fall_data = 8'h00;
    int busy_left = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            tgt_rdy = 1; tgt_done = 0; busy_left = 0; prev_wr = 1; rx_q.delete();
        end else begin
            if (prev_wr && !cfg_wr_n) begin
                fall_data = cfg_data;
                check(tgt_rdy == 1'b1, "R3 strobe while busy", int'(tgt_rdy), 1);
            end else if (!prev_wr && cfg_wr_n) begin
                check(cfg_data == fall_data, "R4 data moved under strobe", int'(cfg_data), int'(fall_data));
                busy_left = (rx_q.size() == sc_stuck) ? 1000000 : busy_len(rx_q.size());
                rx_q.push_back(cfg_data);
                tgt_rdy = 0;
            end else if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    tgt_rdy = 1;
                    if (rx_q.size() >= sc_done_at) tgt_done = 1;
                end
            end
            prev_wr = cfg_wr_n;
        end
    end

    // ---------------- scenarios ----------------
    task automatic run_case(input int n, input int d_at, input int stuck, input bit gaps);
        int idx, gapc, guard, waitc, exp_stat, exp_rx;
        bit rdy_prev;
        string tag;
        sc_done_at = d_at; sc_stuck = stuck;
        @(negedge clk);
        rst_n = 0; in_valid = 0; in_data = 0; in_last = 0;
        @(negedge clk);
        @(negedge clk);
        check(!cfg_data_oe && cfg_wr_n && in_ready && ld_status == 2'd0, "R13 reset state",
              int'({cfg_data_oe, cfg_wr_n, in_ready, ld_status}), int'(5'b01100));
        @(negedge clk);
        rst_n = 1;
        idx = 0; gapc = 0; guard = 0; waitc = 0; rdy_prev = 0;
        while (waitc < 10) begin
            @(negedge clk);
            guard++;
            if (in_valid && rdy_prev) begin idx++; gapc = gaps ? 3 : 0; end
            if (idx < n && gapc == 0) begin
                in_valid = 1; in_data = byte_of(idx, d_at); in_last = (idx == n - 1);
            end else begin
                in_valid = 0; in_last = 0;
                if (gapc > 0) gapc--;
            end
            rdy_prev = in_ready;
            if (e_stat != 0 || guard > 30000) waitc++;
        end
        if (stuck >= 0) begin
            exp_stat = 2; exp_rx = stuck + 1; tag = "R10 timeout";
        end else if (d_at <= n) begin
            exp_stat = 1; exp_rx = STOP ? d_at : n; tag = STOP ? "R5 stop at done" : "R9 send all";
            check(idx == n, "R5 stream fully consumed", idx, n);
        end else begin
            exp_stat = 3; exp_rx = n; tag = "R11 no done";
        end
        check(int'(ld_status) == exp_stat, {tag, " status"}, int'(ld_status), exp_stat);
        check(rx_q.size() == exp_rx, {tag, " bytes written"}, rx_q.size(), exp_rx);
        for (int i = 0; i < rx_q.size(); i++)
            check(rx_q[i] == byte_of(i, d_at), "R1 byte content", int'(rx_q[i]), int'(byte_of(i, d_at)));
        check(!cfg_data_oe && cfg_wr_n && cfg_data == 8'h00, "R6 bus released",
              int'({cfg_data_oe, cfg_wr_n}), 1);
    endtask

    initial begin
        run_case(6, 4, -1, 1'b0);    // done rises inside the padding
        run_case(5, 5, -1, 1'b1);    // done on the last byte, stream with gaps
        run_case(4, 100, -1, 1'b0);  // done never rises
        run_case(5, 4, 1, 1'b0);     // target stays busy on byte 1
        run_case(3, 1, -1, 1'b1);    // done after the first byte
        fin = 1'b1;
    end
endmodule

module cfg_loader_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    cfg_loader_lane #(.STOP(1'b1)) u_lane_stop (.clk(clk));
    cfg_loader_lane #(.STOP(1'b0)) u_lane_all  (.clk(clk));

    initial begin
        int cyc, c, e;
        cyc = 0;
        while (!(u_lane_stop.fin && u_lane_all.fin) && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        c = u_lane_stop.checks + u_lane_all.checks;
        e = u_lane_stop.errors + u_lane_all.errors;
        if (!(u_lane_stop.fin && u_lane_all.fin)) begin
            c++; e++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", c, e);
        $finish;
    end
endmodule